// File: doc/BRIEF.md
# Peripheral Security Attribute Register File

This block is the programmable state of a protection controller. It keeps a 2-bit access attribute for every securable peripheral and a sticky lock bit per peripheral. It also keeps a set of protected-memory size registers, each guarded by its own lock flag, and two read-only words: one reports the hardware configuration and one reports the revision. The attribute of every peripheral and the size of every zone leave the block as flat vectors, which the downstream firewalls read.

Software reaches the block through a simple 32-bit register port: a byte address, a write enable, write data, and a secure flag that qualifies the access. Read data is combinational from the address. A write is taken on the rising clock edge. Locks can only be set. Once set, a lock freezes the field it guards until the next reset. Only secure requests can change any state. Non-secure requests may read the configuration and revision words and nothing else.

Top module: `perisec_regfile`

## Requirements
- R1: After reset every attribute, peripheral lock, zone size and zone lock is 0, so every peripheral starts in the secure-only encoding 0.
- R2: Zone z has its size register at byte offset 4*z. Bits 15:0 hold the size, bits 30:16 read 0, and the size also appears on zoneSizeOut[16*z +: 16].
- R3: Writing a zone register with bit 31 set sets that zone's lock, and bit 31 then reads 1. While the lock is set, writes leave the size unchanged. The lock clears only on reset.
- R4: Attribute words start at byte offset 0x010. Peripheral n sits in word n/16 at bits 2*(n%16)+1:2*(n%16), and the same value appears on attrOut[2*n +: 2].
- R5: Lock words start at byte offset 0x030. Peripheral n sits in word n/32 at bit n%32. Writing 1 to a bit sets that lock and writing 0 changes nothing. Locks read back at the same positions and clear only on reset.
- R6: While a peripheral is locked, writes to its attribute field are ignored. The other fields in the same word still take the written value.
- R7: The word at byte offset 0x3F0 reads {chunk granularity[31:24], bus-master count[23:16], peripheral count[15:8], zone count[7:0]}.
- R8: The word at byte offset 0x3F4 reads the 8-bit revision in bits 7:0, with bits 31:8 at 0.
- R9: Zone, attribute and lock fields for indices at or above the configured counts read 0 and ignore writes. This holds for whole words and for the unused part of a partly filled word.
- R10: A write with the secure flag low changes no register.
- R11: A read with the secure flag low returns the configuration and revision words normally and returns 0 at every other address.
- R12: Addresses that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte address of the access |
| busWe | input | 1 | Write enable, sampled on the rising edge |
| busWdata | input | 32 | Write data |
| busSecure | input | 1 | High for a secure access |
| busRdata | output | 32 | Combinational read data for busAddr |
| attrOut | output | 2*NUM_PERIPH | Attribute of every peripheral, peripheral n at bits 2n+1:2n |
| zoneSizeOut | output | 16*NUM_ZONES | Size of every zone, zone z at bits 16z+15:16z |

## Verification
The bench builds the block with 3 zones and 40 peripherals, 6 bus masters, a chunk code of 2 and revision 0x5A. With these values the fourth zone slot exists in the address map but not in the block. The third attribute word is only half populated. The second lock word has only 8 live bits. The out-of-range reads and writes of R9 can therefore be checked both as whole missing words and as missing fields inside a live word. Locks are set early, and a second reset later shows that all locks clear.

// File: rtl/perisec_pkg.sv
package perisec_pkg;

  // Read source chosen by the decoder
  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_ZONE = 3'd1,
    RD_ATTR = 3'd2,
    RD_LOCK = 3'd3,
    RD_CFG  = 3'd4,
    RD_REV  = 3'd5
  } rdSel_e;

  // Strobes from the decoder to the storage
  typedef struct packed {
    logic       zoneWr;
    logic       attrWr;
    logic       lockWr;
    logic [2:0] wordIdx;
    rdSel_e     rdSel;
  } ctrlStrobe_t;

  // Word-address layout (byte offset / 4); ordering is fixed by the map
  localparam int ZONE_BASE_WA = 0;
  localparam int ATTR_BASE_WA = 4;
  localparam int LOCK_BASE_WA = 12;
  localparam int CFG_WA       = 32'h3F0 >> 2;
  localparam int REV_WA       = 32'h3F4 >> 2;

  localparam int ATTR_PER_WORD = 16;
  localparam int LOCK_PER_WORD = 32;

endpackage

// File: rtl/perisec_ctrl.sv
module perisec_ctrl
  import perisec_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_ZONES  = 2,
  parameter int NUM_PERIPH = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busSecure,
  output ctrlStrobe_t       strb
);

  localparam int WA_W       = ADDR_W - 2;
  localparam int ATTR_WORDS = (NUM_PERIPH + ATTR_PER_WORD - 1) / ATTR_PER_WORD;
  localparam int LOCK_WORDS = (NUM_PERIPH + LOCK_PER_WORD - 1) / LOCK_PER_WORD;

  localparam logic [WA_W-1:0] ZONE_END  = WA_W'(ZONE_BASE_WA + NUM_ZONES);
  localparam logic [WA_W-1:0] ATTR_BASE = WA_W'(ATTR_BASE_WA);
  localparam logic [WA_W-1:0] ATTR_END  = WA_W'(ATTR_BASE_WA + ATTR_WORDS);
  localparam logic [WA_W-1:0] LOCK_BASE = WA_W'(LOCK_BASE_WA);
  localparam logic [WA_W-1:0] LOCK_END  = WA_W'(LOCK_BASE_WA + LOCK_WORDS);
  localparam logic [WA_W-1:0] CFG_ADDR  = WA_W'(CFG_WA);
  localparam logic [WA_W-1:0] REV_ADDR  = WA_W'(REV_WA);

  logic [WA_W-1:0] wordAddr;
  logic [WA_W-1:0] offset;
  logic            inZone;
  logic            inAttr;
  logic            inLock;

  assign wordAddr = busAddr[ADDR_W-1:2];
  assign inZone   = (wordAddr < ZONE_END);
  assign inAttr   = (wordAddr >= ATTR_BASE) && (wordAddr < ATTR_END);
  assign inLock   = (wordAddr >= LOCK_BASE) && (wordAddr < LOCK_END);

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_NONE;
    offset      = '0;
    if (inZone) begin
      offset = wordAddr;
    end else if (inAttr) begin
      offset = wordAddr - ATTR_BASE;
    end else if (inLock) begin
      offset = wordAddr - LOCK_BASE;
    end
    strb.wordIdx = offset[2:0];

    if (busSecure) begin
      if (inZone) begin
        strb.rdSel  = RD_ZONE;
        strb.zoneWr = busWe;
      end else if (inAttr) begin
        strb.rdSel  = RD_ATTR;
        strb.attrWr = busWe;
      end else if (inLock) begin
        strb.rdSel  = RD_LOCK;
        strb.lockWr = busWe;
      end
    end
    if (wordAddr == CFG_ADDR) begin
      strb.rdSel = RD_CFG;
    end else if (wordAddr == REV_ADDR) begin
      strb.rdSel = RD_REV;
    end
  end

  // R10: a non-secure request never raises a write strobe
  a_r10_nonsec_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !busSecure |-> !(strb.zoneWr || strb.attrWr || strb.lockWr));

  // R9: an address between the last live zone and the attribute block never writes a zone
  a_r9_no_phantom_zone: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[ADDR_W-1:2] >= ZONE_END && busAddr[ADDR_W-1:2] < ATTR_BASE) |-> !strb.zoneWr);

  // R11: a non-secure request can only select the configuration or revision word
  a_r11_nonsec_sel: assert property (@(posedge clk) disable iff (!rstN)
    !busSecure |-> (strb.rdSel inside {RD_NONE, RD_CFG, RD_REV}));

endmodule

// File: rtl/perisec_datapath.sv
module perisec_datapath
  import perisec_pkg::*;
#(
  parameter int          NUM_ZONES   = 2,
  parameter int          NUM_PERIPH  = 24,
  parameter int          NUM_MASTERS = 4,
  parameter int          CHUNK_CODE  = 1,
  parameter logic [7:0]  REVISION    = 8'h10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strb,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic [2*NUM_PERIPH-1:0]   attrOut,
  output logic [16*NUM_ZONES-1:0]   zoneSizeOut
);

  localparam logic [31:0] CFG_WORD = {8'(CHUNK_CODE), 8'(NUM_MASTERS),
                                      8'(NUM_PERIPH), 8'(NUM_ZONES)};

  logic [1:0]  attrQ     [NUM_PERIPH];
  logic        perLockQ  [NUM_PERIPH];
  logic [15:0] zoneSizeQ [NUM_ZONES];
  logic        zoneLockQ [NUM_ZONES];

  // Per-peripheral attribute and lock storage
  for (genvar n = 0; n < NUM_PERIPH; n++) begin : g_periph
    localparam logic [2:0] ATTR_WI = 3'(n / ATTR_PER_WORD);
    localparam logic [2:0] LOCK_WI = 3'(n / LOCK_PER_WORD);
    localparam int         ABIT    = 2 * (n % ATTR_PER_WORD);
    localparam int         LBIT    = n % LOCK_PER_WORD;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        attrQ[n] <= 2'b00;
      end else if (strb.attrWr && strb.wordIdx == ATTR_WI && !perLockQ[n]) begin
        attrQ[n] <= wdata[ABIT +: 2];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        perLockQ[n] <= 1'b0;
      end else if (strb.lockWr && strb.wordIdx == LOCK_WI && wdata[LBIT]) begin
        perLockQ[n] <= 1'b1;
      end
    end

    assign attrOut[2*n +: 2] = attrQ[n];

    // R6: a locked peripheral keeps its attribute on the next cycle
    a_r6_locked_attr_frozen: assert property (@(posedge clk) disable iff (!rstN)
      perLockQ[n] |=> $stable(attrQ[n]));

    // R5: a set peripheral lock stays set until reset
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
      perLockQ[n] |=> perLockQ[n]);
  end

  // Per-zone size storage with its own lock
  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    localparam logic [2:0] ZWI = 3'(z);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        zoneSizeQ[z] <= '0;
        zoneLockQ[z] <= 1'b0;
      end else if (strb.zoneWr && strb.wordIdx == ZWI && !zoneLockQ[z]) begin
        zoneSizeQ[z] <= wdata[15:0];
        zoneLockQ[z] <= wdata[31];
      end
    end

    assign zoneSizeOut[16*z +: 16] = zoneSizeQ[z];

    // R3: a locked zone keeps its size and its lock on the next cycle
    a_r3_locked_size_frozen: assert property (@(posedge clk) disable iff (!rstN)
      zoneLockQ[z] |=> ($stable(zoneSizeQ[z]) && zoneLockQ[z]));
  end

  // Read mux
  always_comb begin
    rdata = '0;
    unique case (strb.rdSel)
      RD_ZONE: begin
        for (int z = 0; z < NUM_ZONES; z++) begin
          if (strb.wordIdx == 3'(z)) begin
            rdata = {zoneLockQ[z], 15'b0, zoneSizeQ[z]};
          end
        end
      end
      RD_ATTR: begin
        for (int n = 0; n < NUM_PERIPH; n++) begin
          if (strb.wordIdx == 3'(n / ATTR_PER_WORD)) begin
            rdata[2*(n % ATTR_PER_WORD) +: 2] = attrQ[n];
          end
        end
      end
      RD_LOCK: begin
        for (int n = 0; n < NUM_PERIPH; n++) begin
          if (strb.wordIdx == 3'(n / LOCK_PER_WORD)) begin
            rdata[n % LOCK_PER_WORD] = perLockQ[n];
          end
        end
      end
      RD_CFG:  rdata = CFG_WORD;
      RD_REV:  rdata = {24'b0, REVISION};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/perisec_regfile.sv
module perisec_regfile
  import perisec_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          NUM_ZONES   = 2,
  parameter int          NUM_PERIPH  = 24,
  parameter int          NUM_MASTERS = 4,
  parameter int          CHUNK_CODE  = 1,
  parameter logic [7:0]  REVISION    = 8'h10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWe,
  input  logic [31:0]              busWdata,
  input  logic                     busSecure,
  output logic [31:0]              busRdata,
  output logic [2*NUM_PERIPH-1:0]  attrOut,
  output logic [16*NUM_ZONES-1:0]  zoneSizeOut
);

  // Map limits: at most 4 zones, 128 peripherals
  ctrlStrobe_t strb;

  perisec_ctrl #(
    .ADDR_W    (ADDR_W),
    .NUM_ZONES (NUM_ZONES),
    .NUM_PERIPH(NUM_PERIPH)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busSecure(busSecure),
    .strb     (strb)
  );

  perisec_datapath #(
    .NUM_ZONES  (NUM_ZONES),
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_MASTERS(NUM_MASTERS),
    .CHUNK_CODE (CHUNK_CODE),
    .REVISION   (REVISION)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (busWdata),
    .rdata      (busRdata),
    .attrOut    (attrOut),
    .zoneSizeOut(zoneSizeOut)
  );

  // R10: a non-secure write leaves every output unchanged
  a_r10_nonsec_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !busSecure) |=> ($stable(attrOut) && $stable(zoneSizeOut)));

  // R11: non-secure reads outside the two info words return zero
  a_r11_nonsec_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!busSecure && busAddr[ADDR_W-1:2] != (ADDR_W-2)'(CFG_WA)
                && busAddr[ADDR_W-1:2] != (ADDR_W-2)'(REV_WA)) |-> (busRdata == 32'h0));

endmodule

// File: tb/sim_perisec_regfile.sv
module sim_perisec_regfile;

  localparam int         ADDR_W = 12;
  localparam int         NZ     = 3;
  localparam int         NP     = 40;
  localparam int         NM     = 6;
  localparam int         CHUNK  = 2;
  localparam logic [7:0] REV    = 8'h5A;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWe = 1'b0;
  logic [31:0]       busWdata = '0;
  logic              busSecure = 1'b1;
  logic [31:0]       busRdata;
  logic [2*NP-1:0]   attrOut;
  logic [16*NZ-1:0]  zoneSizeOut;

  always #5 clk = ~clk;

  perisec_regfile #(
    .ADDR_W(ADDR_W), .NUM_ZONES(NZ), .NUM_PERIPH(NP),
    .NUM_MASTERS(NM), .CHUNK_CODE(CHUNK), .REVISION(REV)
  ) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busSecure(busSecure), .busRdata(busRdata),
    .attrOut(attrOut), .zoneSizeOut(zoneSizeOut)
  );

  // Scoreboard item: src 0 = read data, 1 = attrOut field, 2 = zoneSizeOut field
  typedef struct {
    int          src;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];
  int    nChecks = 0;
  int    nFail   = 0;
  bit    pending = 1'b0;

  // Monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (pending && expQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = expQ.pop_front();
      case (it.src)
        0:       act = busRdata;
        1:       act = 32'(attrOut[2*it.idx +: 2]);
        default: act = 32'(zoneSizeOut[16*it.idx +: 16]);
      endcase
      nChecks++;
      if (act !== it.exp) begin
        nFail++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
      pending = 1'b0;
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic sec);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWe = 1'b1; busSecure = sec;
  endtask

  task automatic expect_item(input int src, input int idx, input logic [ADDR_W-1:0] a,
                             input logic sec, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    busWe = 1'b0; busAddr = a; busSecure = sec;
    it.src = src; it.idx = idx; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    pending = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic sec, input logic [31:0] e,
                    input string tag);
    expect_item(0, 0, a, sec, e, tag);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(12'h000, 1'b1, 32'h0, "R1 zone0 after reset");
    rd(12'h010, 1'b1, 32'h0, "R1 attr word0 after reset");
    rd(12'h030, 1'b1, 32'h0, "R1 lock word0 after reset");
    expect_item(1, 39, 12'h000, 1'b1, 32'h0, "R1 attrOut p39 after reset");

    // R2 size field, upper bits masked
    wr(12'h004, 32'h7FFF_1234, 1'b1);
    rd(12'h004, 1'b1, 32'h0000_1234, "R2 zone1 readback");
    expect_item(2, 1, 12'h004, 1'b1, 32'h1234, "R2 zoneSizeOut zone1");

    // R3 zone lock
    wr(12'h008, 32'h8000_00AB, 1'b1);
    rd(12'h008, 1'b1, 32'h8000_00AB, "R3 zone2 lock set");
    wr(12'h008, 32'h0000_5555, 1'b1);
    rd(12'h008, 1'b1, 32'h8000_00AB, "R3 zone2 frozen");
    expect_item(2, 2, 12'h008, 1'b1, 32'h00AB, "R3 zoneSizeOut zone2");

    // R4 attribute placement
    wr(12'h010, 32'h0000_000C, 1'b1);
    rd(12'h010, 1'b1, 32'h0000_000C, "R4 word0 p1");
    expect_item(1, 1, 12'h010, 1'b1, 32'h3, "R4 attrOut p1");
    wr(12'h014, 32'h8000_0001, 1'b1);
    rd(12'h014, 1'b1, 32'h8000_0001, "R4 word1 p16 p31");
    expect_item(1, 31, 12'h014, 1'b1, 32'h2, "R4 attrOut p31");
    expect_item(1, 16, 12'h014, 1'b1, 32'h1, "R4 attrOut p16");

    // R5 set-only locks
    wr(12'h030, 32'h0000_0020, 1'b1);
    rd(12'h030, 1'b1, 32'h0000_0020, "R5 lock p5");
    wr(12'h030, 32'h0000_0001, 1'b1);
    rd(12'h030, 1'b1, 32'h0000_0021, "R5 lock p0 keeps p5");
    wr(12'h030, 32'h0000_0000, 1'b1);
    rd(12'h030, 1'b1, 32'h0000_0021, "R5 zero write no effect");

    // R6 locked fields ignore writes, neighbours writable
    wr(12'h010, 32'hFFFF_FFFF, 1'b1);
    rd(12'h010, 1'b1, 32'hFFFF_F3FC, "R6 locked p0 p5 unchanged");
    expect_item(1, 5, 12'h010, 1'b1, 32'h0, "R6 attrOut p5");

    // R7 R8 info words
    rd(12'h3F0, 1'b1, 32'h0206_2803, "R7 config word");
    rd(12'h3F4, 1'b1, 32'h0000_005A, "R8 revision word");

    // R9 out-of-range indices
    wr(12'h00C, 32'h0000_FFFF, 1'b1);
    rd(12'h00C, 1'b1, 32'h0, "R9 zone3 absent");
    wr(12'h018, 32'hFFFF_FFFF, 1'b1);
    rd(12'h018, 1'b1, 32'h0000_FFFF, "R9 attr word2 partial");
    rd(12'h01C, 1'b1, 32'h0, "R9 attr word3 absent");
    wr(12'h034, 32'hFFFF_FF00, 1'b1);
    rd(12'h034, 1'b1, 32'h0, "R9 lock word1 upper bits");

    // R10 non-secure writes dropped
    wr(12'h004, 32'h0000_BEEF, 1'b0);
    rd(12'h004, 1'b1, 32'h0000_1234, "R10 zone1 kept");
    wr(12'h030, 32'h0000_0002, 1'b0);
    rd(12'h030, 1'b1, 32'h0000_0021, "R10 locks kept");
    wr(12'h014, 32'h0000_0000, 1'b0);
    rd(12'h014, 1'b1, 32'h8000_0001, "R10 attr word1 kept");

    // R11 non-secure reads
    rd(12'h3F0, 1'b0, 32'h0206_2803, "R11 nonsec config");
    rd(12'h3F4, 1'b0, 32'h0000_005A, "R11 nonsec revision");
    rd(12'h004, 1'b0, 32'h0, "R11 nonsec zone hidden");
    rd(12'h030, 1'b0, 32'h0, "R11 nonsec lock hidden");

    // R12 unmapped
    rd(12'h100, 1'b1, 32'h0, "R12 unmapped 0x100");
    rd(12'h3F8, 1'b1, 32'h0, "R12 unmapped 0x3F8");

    // R3 R5: locks clear on reset only
    @(posedge clk); #1 rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    rd(12'h008, 1'b1, 32'h0, "R3 zone lock cleared by reset");
    rd(12'h030, 1'b1, 32'h0, "R5 locks cleared by reset");
    wr(12'h010, 32'h0000_0003, 1'b1);
    rd(12'h010, 1'b1, 32'h0000_0003, "R6 p0 writable after reset");

    @(posedge clk); #1 busWe = 1'b0;
    repeat (2) @(posedge clk);
    if (expQ.size() != 0) begin
      nChecks++; nFail++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size());
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule